// File: doc/BRIEF.md
# Indexed Partial-Word Data Load Unit

This unit performs one indexed load per cycle from a 64-bit tagged data memory. It adds a base word to an index word. The low part of the sum gives a word address and a 3-bit partial-word code. The unit then returns the chosen full word, half word, quarter word or byte, zero-extended and right-justified in a 64-bit result.

Whether the code is read as a byte number or as a word/half/quarter selector is set by a byte-mode attribute. That attribute comes either from the instruction or, when the remote option is set, from one bit of the index operand. Each memory word carries a FULL/EMPTY tag. When the wait attribute is given, a load from an EMPTY word is refused with a not-ready pulse. Without that attribute the tag is ignored. A load never alters a tag.

A simple write port fills the memory model and sets each word's tag. Register write-back is left to the consumer of the result.

Bits are named here by vector index, with bit 63 the most significant bit.

Top module: `pwload_unit`

## Requirements
- R1: After reset the outputs resValid, notReady and codeErr are 0, resData is zero, and every tag is EMPTY, so a waiting load to any word is refused.
- R2: The sum S = baseWord + indexWord (modulo 2^64) gives the word address S[31:3] modulo DEPTH and the partial-word code S[2:0]. A carry out of S[2:0] moves to the next word.
- R3: With byte mode off, code 0 returns the full 64-bit word.
- R4: With byte mode off, code 2 returns word[63:32] in resData[31:0], with the upper bits zero.
- R5: With byte mode off, code 3 returns word[47:32] in resData[15:0], with the upper bits zero.
- R6: With byte mode on, code k (0 to 7) returns word[63-8k -: 8] in resData[7:0], with the upper bits zero.
- R7: When useRemote is 0, byte mode equals instByteMode. When useRemote is 1, byte mode equals indexWord[36] and instByteMode has no effect.
- R8: With byte mode off, codes 1, 4, 5, 6 and 7 give resValid=1, codeErr=1 and resData=0.
- R9: A load with waitFull=1 to a word whose tag is EMPTY gives notReady=1, resValid=0, codeErr=0 and resData=0. Memory and tags are left unchanged.
- R10: A load with waitFull=1 to a FULL word completes, and the tag stays FULL for later loads.
- R11: A load with waitFull=0 completes whatever the tag holds.
- R12: A write with wrEn=1 stores wrData at wrAddr and sets that word's tag to wrTag (1=FULL, 0=EMPTY). A load in a later cycle sees the write.
- R13: Results are registered. The outputs for a load presented with ldValid=1 appear one cycle later. In a cycle after ldValid=0, resValid, notReady and codeErr are 0 and resData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Memory write strobe |
| wrAddr | input | AW | Memory write word address |
| wrData | input | 64 | Memory write data |
| wrTag | input | 1 | Tag written with the data (1=FULL) |
| ldValid | input | 1 | Load request this cycle |
| baseWord | input | 64 | Base operand |
| indexWord | input | 64 | Index operand |
| useRemote | input | 1 | Take the byte-mode attribute from indexWord[36] |
| instByteMode | input | 1 | Byte-mode attribute from the instruction |
| waitFull | input | 1 | Require a FULL tag before reading |
| resValid | output | 1 | Result valid |
| resData | output | 64 | Right-justified, zero-extended result |
| notReady | output | 1 | Load refused because the tag was EMPTY |
| codeErr | output | 1 | Reserved partial-word code |

## Verification
All four outputs are due exactly one clock edge after the edge that samples ldValid. A write is visible to a load presented at the next edge. The bench drives every stimulus on the falling edge and samples 1 ns after the following rising edge, so each check reads the registered result of exactly one request. Idle cycles are checked the same way, to confirm that the flags fall back to zero one cycle after ldValid is removed.

// File: rtl/pwload_pkg.sv
package pwload_pkg;
  localparam int WORD_W = 64;
  localparam int ADDR_LSB = 3;
  localparam int REMOTE_BYTE_BIT = 36;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_FULL,
    SEL_HALF0,
    SEL_QTR1,
    SEL_BYTE
  } sel_e;

  typedef struct packed {
    logic capture;
    logic stall;
    logic err;
    sel_e sel;
  } stb_t;
endpackage

// File: rtl/pwload_ctrl.sv
module pwload_ctrl
  import pwload_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldValid,
  input  logic       waitFull,
  input  logic       tagFull,
  input  logic [2:0] code,
  input  logic       useRemote,
  input  logic       remoteByte,
  input  logic       instByteMode,
  output stb_t       stb
);
  logic byteMode;
  logic reserved;
  sel_e selNext;

  assign byteMode = useRemote ? remoteByte : instByteMode;

  always_comb begin
    reserved = 1'b0;
    selNext  = SEL_ZERO;
    if (byteMode) begin
      selNext = SEL_BYTE;
    end else begin
      case (code)
        3'd0: selNext = SEL_FULL;
        3'd2: selNext = SEL_HALF0;
        3'd3: selNext = SEL_QTR1;
        default: reserved = 1'b1;
      endcase
    end
  end

  always_comb begin
    stb.stall   = ldValid & waitFull & ~tagFull;
    stb.capture = ldValid & ~stb.stall;
    stb.err     = stb.capture & reserved;
    stb.sel     = stb.capture ? selNext : SEL_ZERO;
  end

  // R9: a refusal only happens when the wait attribute was requested
  p_stall_needs_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.stall |-> waitFull);
  // R11: without the wait attribute a request is always accepted
  p_nowait_accepts_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && !waitFull) |-> stb.capture);
endmodule

// File: rtl/pwload_dp.sv
module pwload_dp
  import pwload_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrTag,
  input  logic [WORD_W-1:0] baseWord,
  input  logic [WORD_W-1:0] indexWord,
  input  stb_t              stb,
  output logic [2:0]        code,
  output logic              tagFull,
  output logic              resValid,
  output logic [WORD_W-1:0] resData,
  output logic              notReady,
  output logic              codeErr
);
  logic [WORD_W-1:0] sum;
  logic [AW-1:0]     rdAddr;
  logic [WORD_W-1:0] memQ [DEPTH];
  logic [DEPTH-1:0]  tagQ;
  logic [WORD_W-1:0] wordRd;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] field;
  logic              unusedSumBits;

  assign sum    = baseWord + indexWord;
  assign code   = sum[2:0];
  assign rdAddr = sum[ADDR_LSB +: AW];
  assign unusedSumBits = ^sum[WORD_W-1:ADDR_LSB+AW];

  assign wordRd  = memQ[rdAddr];
  assign tagFull = tagQ[rdAddr];
  assign shifted = wordRd >> {3'd7 - code, 3'b000};

  always_comb begin
    case (stb.sel)
      SEL_FULL:  field = wordRd;
      SEL_HALF0: field = {32'b0, wordRd[63:32]};
      SEL_QTR1:  field = {48'b0, wordRd[47:32]};
      SEL_BYTE:  field = shifted & 64'hFF;
      default:   field = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wrEn) memQ[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ <= '0;
    end else if (wrEn) begin
      tagQ[wrAddr] <= wrTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resData  <= '0;
      notReady <= 1'b0;
      codeErr  <= 1'b0;
    end else begin
      resValid <= stb.capture;
      resData  <= field;
      notReady <= stb.stall;
      codeErr  <= stb.err;
    end
  end

  // R9, R10: reads never disturb the tags
  p_tags_only_written_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(tagQ));
endmodule

// File: rtl/pwload_unit.sv
module pwload_unit
  import pwload_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [63:0]   wrData,
  input  logic          wrTag,
  input  logic          ldValid,
  input  logic [63:0]   baseWord,
  input  logic [63:0]   indexWord,
  input  logic          useRemote,
  input  logic          instByteMode,
  input  logic          waitFull,
  output logic          resValid,
  output logic [63:0]   resData,
  output logic          notReady,
  output logic          codeErr
);
  stb_t       stb;
  logic [2:0] code;
  logic       tagFull;

  pwload_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .waitFull(waitFull),
    .tagFull(tagFull), .code(code), .useRemote(useRemote),
    .remoteByte(indexWord[REMOTE_BYTE_BIT]), .instByteMode(instByteMode),
    .stb(stb)
  );

  pwload_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrTag(wrTag), .baseWord(baseWord), .indexWord(indexWord), .stb(stb),
    .code(code), .tagFull(tagFull), .resValid(resValid), .resData(resData),
    .notReady(notReady), .codeErr(codeErr)
  );

  // R9: waiting on an EMPTY word is refused in the next cycle
  p_empty_refused_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && waitFull && !tagFull) |=> (notReady && !resValid));
  // R13: no request means quiet flags in the next cycle
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !ldValid |=> (!resValid && !notReady && !codeErr));
  // R8: an error result carries zero data
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> (resValid && resData == 64'd0));
  // R9: refused and valid never coincide
  p_refuse_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(notReady && resValid));
endmodule

// File: tb/pwload_unit_test.sv
`timescale 1ns/1ps
module pwload_unit_test;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [63:0]   wrData = '0;
  logic          wrTag = 1'b0;
  logic          ldValid = 1'b0;
  logic [63:0]   baseWord = '0;
  logic [63:0]   indexWord = '0;
  logic          useRemote = 1'b0;
  logic          instByteMode = 1'b0;
  logic          waitFull = 1'b0;
  logic          resValid;
  logic [63:0]   resData;
  logic          notReady;
  logic          codeErr;

  int nChecks = 0;
  int nFails = 0;
  logic [63:0] bm [DEPTH];

  always #2.5 clk = ~clk;

  pwload_unit #(.DEPTH(DEPTH)) uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeWord(input int a, input logic [63:0] d, input logic t);
    @(negedge clk);
    ldValid = 1'b0; wrEn = 1'b1; wrAddr = AW'(a); wrData = d; wrTag = t;
    bm[a] = d;
    @(posedge clk); #1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic load(input logic [63:0] b, input logic [63:0] x,
                      input logic rem, input logic ib, input logic w);
    @(negedge clk);
    wrEn = 1'b0; ldValid = 1'b1; baseWord = b; indexWord = x;
    useRemote = rem; instByteMode = ib; waitFull = w;
    @(posedge clk); #1;
    @(negedge clk);
    ldValid = 1'b0;
  endtask

  function automatic logic [64:0] model(input logic [63:0] w, input logic [2:0] c,
                                        input logic byteMode);
    if (byteMode) return {1'b0, 56'b0, w[63 - 8*int'(c) -: 8]};
    case (c)
      3'd0: return {1'b0, w};
      3'd2: return {1'b0, 32'b0, w[63:32]};
      3'd3: return {1'b0, 48'b0, w[47:32]};
      default: return {1'b1, 64'b0};
    endcase
  endfunction

  task automatic expectOk(input string req, input logic [64:0] m);
    check({req, " valid"}, {63'b0, resValid}, 64'd1);
    check({req, " data"}, resData, m[63:0]);
    check({req, " err"}, {63'b0, codeErr}, {63'b0, m[64]});
    check({req, " notReady"}, {63'b0, notReady}, 64'd0);
  endtask

  task automatic t_reset();
    check("R1 valid", {63'b0, resValid}, 64'd0);
    check("R1 data", resData, 64'd0);
    check("R1 notReady", {63'b0, notReady}, 64'd0);
    load(64'd7 << 3, 64'd0, 1'b0, 1'b0, 1'b1);
    check("R1 empty tag refuses", {63'b0, notReady}, 64'd1);
  endtask

  task automatic t_full_addr();
    writeWord(5, 64'h0123_4567_89AB_CDEF, 1'b1);
    load(64'd5 << 3, 64'd0, 1'b0, 1'b0, 1'b0);
    expectOk("R3 R12 full", model(bm[5], 3'd0, 1'b0));
    load(64'd21 << 3, 64'd0, 1'b0, 1'b0, 1'b0);
    expectOk("R2 wrap", model(bm[5], 3'd0, 1'b0));
  endtask

  task automatic t_half_quarter();
    writeWord(3, 64'hFEDC_BA98_7654_3210, 1'b1);
    load((64'd2 << 3) | 64'd7, 64'd3, 1'b0, 1'b0, 1'b0);
    expectOk("R2 R4 carry half", model(bm[3], 3'd2, 1'b0));
    load(64'd3 << 3, 64'd3, 1'b0, 1'b0, 1'b0);
    expectOk("R5 quarter", model(bm[3], 3'd3, 1'b0));
  endtask

  task automatic t_bytes();
    writeWord(9, 64'h1122_3344_5566_7788, 1'b1);
    for (int k = 0; k < 8; k++) begin
      load(64'd9 << 3, 64'(k), 1'b0, 1'b1, 1'b0);
      expectOk("R6 byte", model(bm[9], 3'(k), 1'b1));
    end
  endtask

  task automatic t_remote();
    load(64'd9 << 3, (64'd1 << 36) | 64'd3, 1'b1, 1'b0, 1'b0);
    expectOk("R7 remote byte", model(bm[9], 3'd3, 1'b1));
    load(64'd9 << 3, 64'd3, 1'b1, 1'b1, 1'b0);
    expectOk("R7 remote ignores inst", model(bm[9], 3'd3, 1'b0));
    load(64'd9 << 3, 64'd3, 1'b0, 1'b1, 1'b0);
    expectOk("R7 inst byte", model(bm[9], 3'd3, 1'b1));
  endtask

  task automatic t_reserved();
    for (int c = 1; c < 8; c++) begin
      if (c == 2 || c == 3) continue;
      load(64'd5 << 3, 64'(c), 1'b0, 1'b0, 1'b0);
      expectOk("R8 reserved", model(bm[5], 3'(c), 1'b0));
    end
  endtask

  task automatic t_wait();
    writeWord(12, 64'hA5A5_0000_FFFF_1234, 1'b0);
    load(64'd12 << 3, 64'd0, 1'b0, 1'b0, 1'b1);
    check("R9 notReady", {63'b0, notReady}, 64'd1);
    check("R9 valid", {63'b0, resValid}, 64'd0);
    check("R9 data", resData, 64'd0);
    load(64'd12 << 3, 64'd0, 1'b0, 1'b0, 1'b0);
    expectOk("R11 no wait", model(bm[12], 3'd0, 1'b0));
    load(64'd12 << 3, 64'd0, 1'b0, 1'b0, 1'b1);
    check("R9 tag still empty", {63'b0, notReady}, 64'd1);
    writeWord(12, 64'h0F0F_1111_2222_3333, 1'b1);
    load(64'd12 << 3, 64'd2, 1'b0, 1'b0, 1'b1);
    expectOk("R10 full", model(bm[12], 3'd2, 1'b0));
    load(64'd12 << 3, 64'd0, 1'b0, 1'b0, 1'b1);
    expectOk("R10 stays full", model(bm[12], 3'd0, 1'b0));
  endtask

  task automatic t_idle();
    @(negedge clk);
    ldValid = 1'b0;
    @(posedge clk); #1;
    check("R13 idle valid", {63'b0, resValid}, 64'd0);
    check("R13 idle data", resData, 64'd0);
    check("R13 idle flags", {62'b0, notReady, codeErr}, 64'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_full_addr();
    t_half_quarter();
    t_bytes();
    t_remote();
    t_reserved();
    t_wait();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule